// File: doc/BRIEF.md
# SDRAM Command Sequence Monitor

This block watches the registered command bus of an SDRAM interface, one command per clock, and reports commands that are illegal given what the banks are doing. It keeps a small model of the device. Each bank is either idle or open. A single tracker follows the one data burst that can be on the bus at a time: which bank owns it, whether it is a read or a write, whether it carries auto precharge, and how many beats are left.

Each command is checked against three kinds of rule:
- Global commands are legal only when no bank is open.
- A burst stop must name the bank that owns the running burst.
- A write that cuts a read short must be preceded by the data mask. The mask is needed one clock ahead, or two clocks ahead when the read carries auto precharge.

Any other command that does not fit the model's state is reported as well.

A rejected command is flagged one clock later as a single-cycle pulse with a reason code. A sticky flag stays set until reset. The model ignores rejected commands, so checking continues from the last legal state. The block is intended to sit beside a memory controller in simulation or in silicon as a protocol guard.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n` as follows, with cs_n high meaning deselect:
  - 0111 is NOP.
  - 0011 is ACTIVE.
  - 0101 is READ.
  - 0100 is WRITE.
  - 0110 is BURST STOP.
  - 0010 is PRECHARGE.
  - 0001 is REFRESH (auto or self).
  - 0000 is MODE LOAD.

  After reset every bank is idle, no burst runs, and err_pulse, err_code and err_sticky are all 0.
- R2: REFRESH or MODE LOAD while any bank is open gives code 1. With all banks idle they are legal.
- R3: BURST STOP gives code 2 in any of three cases: no burst is running, `bank` differs from the burst's bank, or the running burst has auto precharge. A legal BURST STOP ends the burst.
- R4: Code 4 is given in each of these cases:
  - ACTIVE to an open bank.
  - READ or WRITE to an idle bank.
  - READ or WRITE to a bank whose auto-precharge burst is still running.
  - A single-bank PRECHARGE (`ap`=0) to such a bank.
- R5: A WRITE issued while a READ burst without auto precharge runs gives code 3 unless dqm was high in the previous cycle.
- R6: A WRITE issued while a READ burst with auto precharge runs gives code 3 unless dqm was high two cycles earlier. dqm one cycle earlier does not satisfy this rule.
- R7: A burst lasts BURST_LEN cycles, counting the command cycle. When a burst with auto precharge completes, its bank becomes idle. A burst without auto precharge leaves its bank open.
- R8: A legal READ or WRITE to another bank, issued while an auto-precharge burst runs, ends that burst and makes its bank idle.
- R9: err_pulse is high for exactly the one cycle after a rejected command. err_code holds the reason during that cycle and is 0 whenever err_pulse is low.
- R10: err_sticky rises with the first err_pulse and stays high until reset.
- R11: A rejected command changes neither bank state nor the burst tracker. Only the beat countdown of a running burst continues.
- R12: PRECHARGE with `ap`=0 closes `bank`, and with `ap`=1 closes all banks. Precharging an idle bank is legal. A precharge that covers the burst's bank ends the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the command bus is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | BANK_W | Bank address of the command |
| ap | input | 1 | Address bit selecting auto precharge on READ/WRITE, all banks on PRECHARGE |
| dqm | input | 1 | Data mask, high means masked |
| err_pulse | output | 1 | One-cycle flag for a rejected command |
| err_code | output | 3 | Reason: 1 global, 2 burst stop, 3 mask setup, 4 bank state |
| err_sticky | output | 1 | Set by any error, cleared only by reset |

## Verification
The assertions assume the following about the inputs:
- The command bus is stable around the rising edge.
- Clock enable is held high.
- Timing gaps such as activate-to-column delay are respected or do not matter, because the model opens a bank the moment ACTIVE is legal.
- The read window is counted from the command, not from the first data beat.

The stimulus changes inputs only on the falling edge and issues one command per cycle. A single fixed burst length of four is used. The sequence walks through each bank state and each burst kind before it issues the command under test.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int CNT_W = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] bank,
  input  logic              ap,
  input  logic              dqm,
  output logic              err_pulse,
  output logic [2:0]        err_code,
  output logic              err_sticky
);
  localparam logic [2:0] E_NONE = 3'd0, E_GLOBAL = 3'd1, E_TERM = 3'd2,
                         E_DQM = 3'd3, E_STATE = 3'd4;

  wire [2:0] op = {ras_n, cas_n, we_n};
  wire c_act = !cs_n && op == 3'b011;
  wire c_rd  = !cs_n && op == 3'b101;
  wire c_wr  = !cs_n && op == 3'b100;
  wire c_bst = !cs_n && op == 3'b110;
  wire c_pre = !cs_n && op == 3'b010;
  wire c_ref = !cs_n && op == 3'b001;
  wire c_lmr = !cs_n && op == 3'b000;

  logic [NUM_BANKS-1:0] open_q;
  logic [CNT_W-1:0]     left_q;
  logic [BANK_W-1:0]    bbank_q;
  logic                 brd_q, bap_q, dqm_d1, dqm_d2;

  wire busy     = left_q != '0;
  wire tgt_open = open_q[bank];
  wire tgt_lock = busy && bap_q && bbank_q == bank;

  logic [2:0] code;
  always_comb begin
    code = E_NONE;
    if ((c_ref || c_lmr) && |open_q)
      code = E_GLOBAL;
    else if (c_bst && (!busy || bap_q || bbank_q != bank))
      code = E_TERM;
    else if ((c_act && tgt_open) ||
             ((c_rd || c_wr) && (!tgt_open || tgt_lock)) ||
             (c_pre && !ap && tgt_lock))
      code = E_STATE;
    else if (c_wr && busy && brd_q && !(bap_q ? dqm_d2 : dqm_d1))
      code = E_DQM;
  end

  wire ok = code == E_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= '0;
      left_q     <= '0;
      bbank_q    <= '0;
      brd_q      <= 1'b0;
      bap_q      <= 1'b0;
      dqm_d1     <= 1'b0;
      dqm_d2     <= 1'b0;
      err_pulse  <= 1'b0;
      err_code   <= E_NONE;
      err_sticky <= 1'b0;
    end else begin
      dqm_d1    <= dqm;
      dqm_d2    <= dqm_d1;
      err_pulse <= !ok;
      err_code  <= code;
      if (!ok) err_sticky <= 1'b1;

      if (busy) begin
        left_q <= left_q - CNT_W'(1);
        if (left_q == CNT_W'(1) && bap_q) open_q[bbank_q] <= 1'b0;
      end

      if (ok) begin
        if (c_act) open_q[bank] <= 1'b1;
        if (c_rd || c_wr) begin
          if (busy && bap_q && bbank_q != bank) open_q[bbank_q] <= 1'b0;
          left_q  <= CNT_W'(BURST_LEN - 1);
          bbank_q <= bank;
          brd_q   <= c_rd;
          bap_q   <= ap;
          if (BURST_LEN == 1 && ap) open_q[bank] <= 1'b0;
        end
        if (c_bst) left_q <= '0;
        if (c_pre) begin
          if (ap) open_q <= '0;
          else    open_q[bank] <= 1'b0;
          if (busy && (ap || bbank_q == bank)) left_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int CNT_W = $clog2(BURST_LEN + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [BANK_W-1:0]    bank,
  input logic                 err_pulse,
  input logic [2:0]           err_code,
  input logic                 err_sticky,
  input logic [NUM_BANKS-1:0] open_q,
  input logic [CNT_W-1:0]     left_q,
  input logic [BANK_W-1:0]    bbank_q,
  input logic                 brd_q,
  input logic                 bap_q,
  input logic                 dqm_d1,
  input logic                 dqm_d2
);
  wire is_wr  = !cs_n && ras_n && !cas_n && !we_n;
  wire is_bst = !cs_n && ras_n && cas_n && !we_n;
  wire is_glb = !cs_n && !ras_n && !cas_n;
  wire cut_ok = is_wr && open_q[bank] && left_q != '0 && brd_q && bbank_q != bank;

  assert_code_with_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse == (err_code != 3'd0));

  assert_sticky_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  assert_global_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_glb && |open_q |=> err_pulse && err_code == 3'd1);

  assert_stop_wrong_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_bst && left_q != '0 && bank != bbank_q |=> err_code == 3'd2);

  assert_mask_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cut_ok && !bap_q && !dqm_d1 |=> err_code == 3'd3);

  assert_mask_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cut_ok && bap_q && !dqm_d2 |=> err_code == 3'd3);
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
  .NUM_BANKS(NUM_BANKS), .BURST_LEN(BURST_LEN)
) i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .bank(bank), .err_pulse(err_pulse), .err_code(err_code),
  .err_sticky(err_sticky), .open_q(open_q), .left_q(left_q),
  .bbank_q(bbank_q), .brd_q(brd_q), .bap_q(bap_q), .dqm_d1(dqm_d1),
  .dqm_d2(dqm_d2)
);

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_BST = 4'b0110, C_PRE = 4'b0010,
                         C_REF = 4'b0001, C_LMR = 4'b0000;
  localparam int NV = 49;
  // {req[3:0], cmd[3:0], bank[1:0], ap, dqm, expected code[2:0]}
  localparam logic [14:0] VEC [NV] = '{
    {4'd1,  C_NOP, 2'd0, 1'b0, 1'b0, 3'd0},  // R1 nop after reset
    {4'd2,  C_LMR, 2'd0, 1'b0, 1'b0, 3'd0},  // R2 all idle
    {4'd2,  C_REF, 2'd0, 1'b0, 1'b0, 3'd0},  // R2
    {4'd4,  C_ACT, 2'd0, 1'b0, 1'b0, 3'd0},  // R4 open b0
    {4'd2,  C_REF, 2'd0, 1'b0, 1'b0, 3'd1},  // R2 bank open
    {4'd4,  C_ACT, 2'd0, 1'b0, 1'b0, 3'd4},  // R4 act open bank
    {4'd4,  C_RD,  2'd1, 1'b0, 1'b0, 3'd4},  // R4 read idle bank
    {4'd5,  C_RD,  2'd0, 1'b0, 1'b0, 3'd0},  // R5 read b0
    {4'd5,  C_NOP, 2'd0, 1'b0, 1'b1, 3'd0},  // R5 mask one ahead
    {4'd5,  C_WR,  2'd0, 1'b0, 1'b0, 3'd0},  // R5 legal cut
    {4'd3,  C_NOP, 2'd0, 1'b0, 1'b0, 3'd0},
    {4'd3,  C_BST, 2'd1, 1'b0, 1'b0, 3'd2},  // R3 wrong bank
    {4'd3,  C_BST, 2'd0, 1'b0, 1'b0, 3'd0},  // R3 right bank
    {4'd3,  C_BST, 2'd0, 1'b0, 1'b0, 3'd2},  // R3 no burst
    {4'd5,  C_RD,  2'd0, 1'b0, 1'b0, 3'd0},
    {4'd5,  C_NOP, 2'd0, 1'b0, 1'b0, 3'd0},
    {4'd5,  C_WR,  2'd0, 1'b0, 1'b0, 3'd3},  // R5 missing mask
    {4'd5,  C_NOP, 2'd0, 1'b0, 1'b0, 3'd0},
    {4'd8,  C_ACT, 2'd1, 1'b0, 1'b0, 3'd0},
    {4'd6,  C_RD,  2'd1, 1'b1, 1'b1, 3'd0},  // R6 auto-precharge read, mask now
    {4'd6,  C_NOP, 2'd0, 1'b0, 1'b0, 3'd0},
    {4'd6,  C_WR,  2'd0, 1'b0, 1'b0, 3'd0},  // R6 mask two ahead ok
    {4'd8,  C_ACT, 2'd1, 1'b0, 1'b0, 3'd0},  // R8 b1 closed by cut
    {4'd8,  C_NOP, 2'd0, 1'b0, 1'b0, 3'd0},
    {4'd8,  C_NOP, 2'd0, 1'b0, 1'b0, 3'd0},
    {4'd6,  C_RD,  2'd1, 1'b1, 1'b0, 3'd0},
    {4'd6,  C_NOP, 2'd0, 1'b0, 1'b1, 3'd0},
    {4'd6,  C_WR,  2'd0, 1'b0, 1'b0, 3'd3},  // R6 one ahead not enough
    {4'd7,  C_NOP, 2'd0, 1'b0, 1'b0, 3'd0},
    {4'd7,  C_ACT, 2'd1, 1'b0, 1'b0, 3'd0},  // R7 closed at burst end
    {4'd7,  C_RD,  2'd1, 1'b0, 1'b0, 3'd0},
    {4'd7,  C_NOP, 2'd0, 1'b0, 1'b0, 3'd0},
    {4'd7,  C_NOP, 2'd0, 1'b0, 1'b0, 3'd0},
    {4'd7,  C_NOP, 2'd0, 1'b0, 1'b0, 3'd0},
    {4'd7,  C_ACT, 2'd1, 1'b0, 1'b0, 3'd4},  // R7 still open
    {4'd4,  C_RD,  2'd2, 1'b0, 1'b0, 3'd4},
    {4'd12, C_PRE, 2'd1, 1'b0, 1'b0, 3'd0},  // R12 close b1
    {4'd12, C_PRE, 2'd1, 1'b0, 1'b0, 3'd0},  // R12 idle bank ok
    {4'd12, C_RD,  2'd1, 1'b0, 1'b0, 3'd4},  // R12 b1 closed
    {4'd2,  C_REF, 2'd0, 1'b0, 1'b0, 3'd1},
    {4'd12, C_PRE, 2'd0, 1'b1, 1'b0, 3'd0},  // R12 all banks
    {4'd2,  C_LMR, 2'd0, 1'b0, 1'b0, 3'd0},
    {4'd4,  C_ACT, 2'd2, 1'b0, 1'b0, 3'd0},
    {4'd4,  C_WR,  2'd2, 1'b1, 1'b0, 3'd0},
    {4'd3,  C_BST, 2'd2, 1'b0, 1'b0, 3'd2},  // R3 auto-precharge burst
    {4'd4,  C_PRE, 2'd2, 1'b0, 1'b0, 3'd4},  // R4 precharging bank
    {4'd11, C_ACT, 2'd2, 1'b0, 1'b0, 3'd4},  // R11 PRE was ignored
    {4'd7,  C_NOP, 2'd0, 1'b0, 1'b0, 3'd0},
    {4'd7,  C_ACT, 2'd2, 1'b0, 1'b0, 3'd0}   // R7 closed after write burst
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, ap, dqm;
  logic [1:0] bank;
  logic err_pulse, err_sticky;
  logic [2:0] err_code;
  int n_checks = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdram_cmd_monitor i_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bank(bank), .ap(ap), .dqm(dqm), .err_pulse(err_pulse),
    .err_code(err_code), .err_sticky(err_sticky)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [1:0] b, input logic a, input logic m);
    {cs_n, ras_n, cas_n, we_n} = c;
    bank = b; ap = a; dqm = m;
  endtask

  initial begin
    drive(C_NOP, 2'd0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 reset pulse", int'(err_pulse), 0);
    chk("R10 reset sticky", int'(err_sticky), 0);
    rst_n = 1'b1;
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk($sformatf("R%0d vector %0d code", VEC[i-1][14:11], i - 1),
            int'(err_code), int'(VEC[i-1][2:0]));
        chk($sformatf("R9 vector %0d pulse", i - 1),
            int'(err_pulse), int'(VEC[i-1][2:0] != 3'd0));
      end
      if (i < NV) drive(VEC[i][10:7], VEC[i][6:5], VEC[i][4], VEC[i][3]);
      else drive(C_NOP, 2'd0, 1'b0, 1'b0);
    end
    chk("R10 sticky after errors", int'(err_sticky), 1);

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset code", int'(err_code), 0);
    chk("R10 sticky cleared", int'(err_sticky), 0);
    rst_n = 1'b1;
    drive(C_REF, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R1 all banks idle after reset", int'(err_code), 0);
    drive(C_ACT, 2'd3, 1'b0, 1'b0);
    @(negedge clk);
    drive(C_LMR, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    drive(C_NOP, 2'd0, 1'b0, 1'b0);
    chk("R9 pulse cycle", int'(err_pulse), 1);
    chk("R9 reason", int'(err_code), 1);
    chk("R10 sticky rises", int'(err_sticky), 1);
    @(negedge clk);
    chk("R9 pulse ends", int'(err_pulse), 0);
    chk("R9 code cleared", int'(err_code), 0);
    repeat (5) @(negedge clk);
    chk("R10 sticky held", int'(err_sticky), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL all: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule